// File: doc/BRIEF.md
# System Control and Power-Fail Register Block

This block gathers a handful of small housekeeping registers behind one register bus: a configuration byte, a diagnostic byte, a modem-control byte, a miscellaneous-functions byte, a power-control byte and a 32-bit system-control word. Each byte register answers only to single-byte accesses. The system-control word answers only to 4-byte accesses. Reads return data one cycle after the request and have no side effects.

A power-fail status bit follows the external power-failing input, but only while the configuration byte enables power interrupts. Software can clear that bit and can never set it. The interrupt output is the status bit ANDed with the enable bit. Three write-triggered single-cycle pulses leave the block: a power-off request, a system-reset request and a terminal-count strobe for a floppy controller.

A system-reset request leaves a status value in the system-control word. That value survives the block reset which the request is expected to cause. There are two reset inputs. The cold reset clears everything. The block reset spares the diagnostic and system-control registers.

Top module: `sysctl_regblk`

## Requirements
- R1: The byte registers sit at byte offsets 0 (configuration), 1 (diagnostic), 2 (modem control), 3 (misc functions) and 4 (power control). The system-control word sits at offset 8. A read with `rd_en` high returns the addressed contents, zero-extended, on `rdata` after the next rising edge. Unmapped offsets read as zero.
- R2: Byte registers need `acc_word`=0 and the system-control word needs `acc_word`=1. An access of the wrong size writes nothing and reads back zero.
- R3: `pf_irq` is high exactly when power-control bit 5 (status) and configuration bit 3 (enable) are both 1.
- R4: On any rising clock edge where `pwr_fail` differs from its value at the previous edge, the status bit becomes `pwr_fail` AND configuration bit 3, using the configuration held before that edge. At other edges the input has no effect on the status bit.
- R5: A byte write to power control stores data bits 0 and 1. All other data bits are ignored. The status bit is kept unless data bit 1 is 1, in which case it clears. If an input change occurs on the same edge, the input-change rule of R4 sets the status bit instead.
- R6: A byte write to power control with data bit 0 set raises `pwroff_req` for exactly the following cycle.
- R7: A byte write to misc functions with data bit 0 set raises `tc_pulse` for the following cycle. The register stores the data with bit 0 forced to 0.
- R8: A word write to system control with data bit 0 set loads the word with 0x00000002 and raises `sysrst_req` for the following cycle. Any other word write stores the data as written.
- R9: Block reset (`rst_n` low) clears configuration, modem control, misc functions, power control and the sampled input history. The diagnostic and system-control registers keep their values. Cold reset (`por_n` low) clears all registers.
- R10: Reads change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, active low, asynchronous, clears all state |
| rst_n | input | 1 | Block reset, active low, asynchronous, spares diagnostic and system-control |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| acc_word | input | 1 | 1 = 4-byte access, 0 = single-byte access |
| wdata | input | DATA_W | Write data, byte registers take bits 7:0 |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| pwr_fail | input | 1 | Power-failing indication |
| pf_irq | output | 1 | Power-fail interrupt |
| pwroff_req | output | 1 | Single-cycle power-off request |
| sysrst_req | output | 1 | Single-cycle system-reset request |
| tc_pulse | output | 1 | Single-cycle terminal-count strobe |

## Verification
The bench toggles the power-failing input while the enable bit is off, then turns the enable on without any input change. A design that evaluates the status bit level-sensitively, rather than on input changes, would raise the interrupt here. It also lands an interrupt-clear write on the same edge as an input change, where wrong priority would drop a status that should be set. A block reset is applied after a reset request, so a design that clears the system-control word or the diagnostic byte shows zero instead of the retained values. Wrong-size accesses to every register are mixed in at random, and a decoder that ignores the size qualifier would corrupt a register or return non-zero data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int NREG    = 6;
  localparam int R_CFG   = 0;
  localparam int R_DIAG  = 1;
  localparam int R_MDM   = 2;
  localparam int R_MISC  = 3;
  localparam int R_PWR   = 4;
  localparam int R_SYS   = 5;

  localparam int OFF_W   = 4;
  localparam logic [OFF_W-1:0] REG_OFF [NREG] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h8};
  localparam logic             REG_WORD[NREG] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  localparam int CFG_EN_BIT  = 3;
  localparam int PWR_OFF_BIT = 0;
  localparam int PWR_CLR_BIT = 1;
  localparam int PWR_ST_BIT  = 5;
  localparam int MISC_TC_BIT = 0;
  localparam int SYS_REQ_BIT = 0;
  localparam logic [7:0] SYS_RST_STATUS = 8'h02;

  localparam int NPULSE  = 3;
  localparam int P_OFF   = 0;
  localparam int P_RST   = 1;
  localparam int P_TC    = 2;
endpackage

// File: rtl/sysctl_bus_dec.sv
module sysctl_bus_dec
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              acc_word,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);
  logic [NREG-1:0] hit;

  // one comparator per register: offset and access size both must match
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit[i] = (addr == ADDR_W'(REG_OFF[i])) && (acc_word == REG_WORD[i]);
  end

  assign wr_sel = hit & {NREG{wr_en}};
  assign rd_sel = hit & {NREG{rd_en}};
endmodule

// File: rtl/sysctl_pwr_unit.sv
module sysctl_pwr_unit
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pf_in,
  input  logic       irq_en,
  input  logic       wr,
  input  logic [7:0] wbyte,
  output logic [7:0] pwr_q,
  output logic       irq
);
  logic       pf_seen;
  logic       status_q;
  logic [1:0] ctl_q;
  logic       pf_evt;
  logic       status_d;

  assign pf_evt = (pf_in != pf_seen);

  always_comb begin
    status_d = status_q;
    if (wr && wbyte[PWR_CLR_BIT]) status_d = 1'b0;
    // an input change overrides a same-edge software clear
    if (pf_evt) status_d = pf_in & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_seen  <= 1'b0;
      status_q <= 1'b0;
      ctl_q    <= 2'b00;
    end else begin
      pf_seen  <= pf_in;
      status_q <= status_d;
      if (wr) ctl_q <= wbyte[1:0];
    end
  end

  always_comb begin
    pwr_q             = 8'h00;
    pwr_q[1:0]        = ctl_q;
    pwr_q[PWR_ST_BIT] = status_q;
  end

  assign irq = status_q & irq_en;
endmodule

// File: rtl/sysctl_pulse_gen.sv
module sysctl_pulse_gen #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_p
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= fire[i];
    end
  end
endmodule

// File: rtl/sysctl_regblk.sv
module sysctl_regblk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              acc_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_fail,
  output logic              pf_irq,
  output logic              pwroff_req,
  output logic              sysrst_req,
  output logic              tc_pulse
);
  localparam int BYTE_W = 8;

  logic              blk_rst_n;
  logic [NREG-1:0]   wr_sel;
  logic [NREG-1:0]   rd_sel;
  logic [BYTE_W-1:0] wbyte;
  logic [BYTE_W-1:0] cfg_q, diag_q, mdm_q, misc_q, pwr_q;
  logic [DATA_W-1:0] sys_q;
  logic [NPULSE-1:0] fire, pulse;
  logic [DATA_W-1:0] rd_val;

  assign blk_rst_n = rst_n & por_n;
  assign wbyte     = wdata[BYTE_W-1:0];

  sysctl_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .acc_word(acc_word),
    .wr_sel  (wr_sel),
    .rd_sel  (rd_sel)
  );

  // registers cleared by either reset
  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      cfg_q  <= '0;
      mdm_q  <= '0;
      misc_q <= '0;
    end else begin
      if (wr_sel[R_CFG])  cfg_q  <= wbyte;
      if (wr_sel[R_MDM])  mdm_q  <= wbyte;
      if (wr_sel[R_MISC]) begin
        misc_q              <= wbyte;
        misc_q[MISC_TC_BIT] <= 1'b0;
      end
    end
  end

  // registers that only a cold reset clears
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      diag_q <= '0;
      sys_q  <= '0;
    end else begin
      if (wr_sel[R_DIAG]) diag_q <= wbyte;
      if (wr_sel[R_SYS]) begin
        if (wdata[SYS_REQ_BIT]) sys_q <= DATA_W'(SYS_RST_STATUS);
        else                    sys_q <= wdata;
      end
    end
  end

  sysctl_pwr_unit u_pwr (
    .clk   (clk),
    .rst_n (blk_rst_n),
    .pf_in (pwr_fail),
    .irq_en(cfg_q[CFG_EN_BIT]),
    .wr    (wr_sel[R_PWR]),
    .wbyte (wbyte),
    .pwr_q (pwr_q),
    .irq   (pf_irq)
  );

  assign fire[P_OFF] = wr_sel[R_PWR]  & wbyte[PWR_OFF_BIT];
  assign fire[P_RST] = wr_sel[R_SYS]  & wdata[SYS_REQ_BIT];
  assign fire[P_TC]  = wr_sel[R_MISC] & wbyte[MISC_TC_BIT];

  sysctl_pulse_gen #(.N(NPULSE)) u_pulse (
    .clk  (clk),
    .rst_n(blk_rst_n),
    .fire (fire),
    .pulse(pulse)
  );

  assign pwroff_req = pulse[P_OFF];
  assign sysrst_req = pulse[P_RST];
  assign tc_pulse   = pulse[P_TC];

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      rd_sel[R_CFG]:  rd_val = DATA_W'(cfg_q);
      rd_sel[R_DIAG]: rd_val = DATA_W'(diag_q);
      rd_sel[R_MDM]:  rd_val = DATA_W'(mdm_q);
      rd_sel[R_MISC]: rd_val = DATA_W'(misc_q);
      rd_sel[R_PWR]:  rd_val = DATA_W'(pwr_q);
      rd_sel[R_SYS]:  rd_val = sys_q;
      default:        rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) rdata <= '0;
    else            rdata <= rd_val;
  end
endmodule

// File: rtl/sysctl_regblk_chk.sv
module sysctl_regblk_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              acc_word,
  input logic [DATA_W-1:0] wdata,
  input logic              pwr_fail,
  input logic              pwroff_req,
  input logic              sysrst_req,
  input logic              tc_pulse,
  input logic [7:0]        cfg_q,
  input logic [7:0]        pwr_q,
  input logic [DATA_W-1:0] sys_q
);
  // R6
  pwroff_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pwroff_req |-> $past(wr_en && !acc_word && addr == ADDR_W'(4) && wdata[0]));

  // R7
  tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    tc_pulse |-> $past(wr_en && !acc_word && addr == ADDR_W'(3) && wdata[0]));

  // R8
  sysrst_status_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sysrst_req |-> (sys_q == DATA_W'(2)) && $past(wr_en && acc_word && addr == ADDR_W'(8)));

  // R4
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(pwr_q[5]) |-> $past(pwr_fail) && $past(cfg_q[3]));

  // R5
  status_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(pwr_q[5]) |-> $past(pwr_fail) != $past(pwr_fail, 2) || $past(pwr_fail) != 1'b0);
endmodule

bind sysctl_regblk sysctl_regblk_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .acc_word  (acc_word),
  .wdata     (wdata),
  .pwr_fail  (pwr_fail),
  .pwroff_req(pwroff_req),
  .sysrst_req(sysrst_req),
  .tc_pulse  (tc_pulse),
  .cfg_q     (cfg_q),
  .pwr_q     (pwr_q),
  .sys_q     (sys_q)
);

// File: tb/sim_sysctl_regblk.sv
module sim_sysctl_regblk;
  localparam int CLK_T  = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              por_n, rst_n;
  logic [ADDR_W-1:0] addr;
  logic              wr_en, rd_en, acc_word;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              pwr_fail;
  logic              pf_irq, pwroff_req, sysrst_req, tc_pulse;

  int total = 0;
  int bad   = 0;

  // bench-side register model
  logic [7:0]  m_cfg, m_diag, m_mdm, m_misc, m_pwr;
  logic [31:0] m_sys;
  logic        m_pfq;

  always #(CLK_T/2) clk = ~clk;

  sysctl_regblk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .acc_word(acc_word), .wdata(wdata), .rdata(rdata),
    .pwr_fail(pwr_fail), .pf_irq(pf_irq), .pwroff_req(pwroff_req),
    .sysrst_req(sysrst_req), .tc_pulse(tc_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a, input logic w);
    if (!w) begin
      case (a)
        4'h0: return {24'h0, m_cfg};
        4'h1: return {24'h0, m_diag};
        4'h2: return {24'h0, m_mdm};
        4'h3: return {24'h0, m_misc};
        4'h4: return {24'h0, m_pwr};
        default: return 32'h0;
      endcase
    end
    return (a == 4'h8) ? m_sys : 32'h0;
  endfunction

  task automatic model_reset(input bit cold);
    m_cfg = 0; m_mdm = 0; m_misc = 0; m_pwr = 0; m_pfq = 0;
    if (cold) begin m_diag = 0; m_sys = 0; end
  endtask

  task automatic model_step(input bit we, input logic [3:0] a, input bit w,
                            input logic [31:0] d, input bit pf);
    bit wb, ww, st;
    wb = we && !w;
    ww = we && w;
    st = m_pwr[5];
    if (wb && a == 4'h4) begin
      if (d[1]) st = 1'b0;
      m_pwr = {2'b00, 1'b0, 3'b000, d[1:0]};
    end
    if (pf != m_pfq) st = pf & m_cfg[3];
    m_pwr[5] = st;
    m_pfq = pf;
    if (wb && a == 4'h0) m_cfg  = d[7:0];
    if (wb && a == 4'h1) m_diag = d[7:0];
    if (wb && a == 4'h2) m_mdm  = d[7:0];
    if (wb && a == 4'h3) m_misc = d[7:0] & 8'hFE;
    if (ww && a == 4'h8) m_sys  = d[0] ? 32'h2 : d;
  endtask

  task automatic step(input bit we, input bit re, input logic [3:0] a, input bit w,
                      input logic [31:0] d, input bit pf);
    logic [31:0] exp_rd;
    bit e_off, e_rst, e_tc;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; acc_word = w; wdata = d; pwr_fail = pf;
    exp_rd = model_read(a, w);
    e_off = we && !w && a == 4'h4 && d[0];
    e_tc  = we && !w && a == 4'h3 && d[0];
    e_rst = we &&  w && a == 4'h8 && d[0];
    @(posedge clk);
    model_step(we, a, w, d, pf);
    #1;
    if (re) begin
      if (w != (a == 4'h8) || !(a <= 4'h4 || a == 4'h8))
        chk(rdata == exp_rd, "R2 wrong-size/unmapped read", rdata, exp_rd);
      else
        chk(rdata == exp_rd, "R1 read data", rdata, exp_rd);
    end
    chk(pwroff_req == e_off, "R6 power-off pulse", pwroff_req, e_off);
    chk(tc_pulse == e_tc, "R7 terminal-count pulse", tc_pulse, e_tc);
    chk(sysrst_req == e_rst, "R8 reset-request pulse", sysrst_req, e_rst);
    chk(pf_irq == (m_pwr[5] & m_cfg[3]), "R3 interrupt", pf_irq, m_pwr[5] & m_cfg[3]);
  endtask

  task automatic rd_chk(input logic [3:0] a, input bit w, input logic [31:0] exp, input string req);
    step(0, 1, a, w, 32'h0, pwr_fail);
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic apply_reset(input bit cold);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (cold) por_n = 0; else rst_n = 0;
    model_reset(cold);
    @(negedge clk);
    por_n = 1; rst_n = 1;
  endtask

  initial begin
    #(CLK_T * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] addr_pool [8];
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    addr_pool = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'h5, 4'hC};
    por_n = 1; rst_n = 1; wr_en = 0; rd_en = 0; addr = 0; acc_word = 0;
    wdata = 0; pwr_fail = 0;
    m_diag = 0; m_sys = 0;
    apply_reset(1);

    // R9 cold reset state
    rd_chk(4'h0, 0, 32'h0, "R9 cfg after cold reset");
    rd_chk(4'h8, 1, 32'h0, "R9 sys after cold reset");

    // R4 input rises with enable off: status stays 0
    step(1, 0, 4'h0, 0, 32'h0, 1);
    step(0, 0, 4'h0, 0, 0, 1);
    step(1, 0, 4'h0, 0, 32'h08, 1);   // enable on, no input change
    rd_chk(4'h4, 0, 32'h0, "R4 enable without input change");
    step(0, 0, 4'h0, 0, 0, 0);
    step(0, 0, 4'h0, 0, 0, 1);        // change with enable on
    rd_chk(4'h4, 0, 32'h20, "R4 status set on change");
    chk(pf_irq == 1'b1, "R3 irq high", pf_irq, 1);

    // R5 software clear, then data bits outside 0..1 ignored
    step(1, 0, 4'h4, 0, 32'hFE, 1);
    rd_chk(4'h4, 0, 32'h02, "R5 clear and store");
    chk(pf_irq == 1'b0, "R3 irq low after clear", pf_irq, 0);

    // R5 clear on the same edge as an input change: change wins
    step(0, 0, 4'h0, 0, 0, 0);
    step(1, 0, 4'h4, 0, 32'h02, 1);
    rd_chk(4'h4, 0, 32'h22, "R5 input change beats clear");

    // R6, R7, R8 directed
    step(1, 0, 4'h4, 0, 32'h01, 1);
    step(1, 0, 4'h3, 0, 32'hFF, 1);
    rd_chk(4'h3, 0, 32'hFE, "R7 misc stores without bit 0");
    step(1, 0, 4'h8, 1, 32'hABCD0000, 1);
    rd_chk(4'h8, 1, 32'hABCD0000, "R8 plain store");
    step(1, 0, 4'h1, 0, 32'h5A, 1);
    step(1, 0, 4'h2, 0, 32'h33, 1);
    step(1, 0, 4'h8, 1, 32'hFFFFFFFF, 1);
    rd_chk(4'h8, 1, 32'h2, "R8 reset status");

    // R2 wrong-size accesses
    step(1, 0, 4'h0, 1, 32'h00, 1);
    rd_chk(4'h0, 0, 32'h08, "R2 word write to byte reg ignored");
    rd_chk(4'h0, 1, 32'h0, "R2 word read of byte reg");
    step(1, 0, 4'h8, 0, 32'h44, 1);
    rd_chk(4'h8, 1, 32'h2, "R2 byte write to word reg ignored");

    // R10 repeated reads stable
    rd_chk(4'h1, 0, 32'h5A, "R10 read no side effect 1");
    rd_chk(4'h1, 0, 32'h5A, "R10 read no side effect 2");

    // R9 block reset keeps diagnostic and system-control
    apply_reset(0);
    rd_chk(4'h1, 0, 32'h5A, "R9 diag kept");
    rd_chk(4'h8, 1, 32'h2, "R9 sys kept");
    rd_chk(4'h2, 0, 32'h0, "R9 modem cleared");
    rd_chk(4'h0, 0, 32'h0, "R9 cfg cleared");

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      bit w, we, re, pf;
      int unsigned r;
      r  = $urandom;
      a  = addr_pool[$urandom % 8];
      w  = ($urandom % 8 == 0) ? (a != 4'h8) : (a == 4'h8);
      we = (r % 3) == 0;
      re = !we && ((r % 3) == 1);
      pf = ($urandom % 6 == 0) ? !pwr_fail : pwr_fail;
      step(we, re, a, w, $urandom, pf);
      if (i % 1000 == 999) apply_reset(($urandom % 2) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule